// File: doc/BRIEF.md
# Increment/Clear Counter with Selectable Conflict Policy

A synchronous up-counter of parameterised width driven by two single-bit requests: an increment request and a clear request. At each rising clock edge the next count is formed from the two requests and the present count. With neither request the count keeps its value. An increment request alone advances the count by one and wraps from all ones to zero. A clear request alone returns the count to zero.

A compile-time parameter fixes what happens when both requests arrive in the same cycle. The four policies are: keep the count, let the increment win, let the clear win, or declare the combination illegal. In the illegal mode the hardware falls back to letting the clear win, and a bound assertion flags any cycle in which both requests are high.

A second registered output is a Moore flag that depends only on the present count. A bit mask parameter over all count values selects the values at which the flag is high. The flag is computed from the next count and registered together with it, so it always matches the count it describes.

Top module: `cnt_incclr`

## Requirements
- R1: While `rst` is high at a rising edge, `count` becomes 0 and `z` becomes `Z_MASK[0]`, whatever `inc` and `clr` are.
- R2: With `inc`=0 and `clr`=0 at an edge, `count` keeps its value.
- R3: With `inc`=1 and `clr`=0 at an edge, `count` becomes the old count plus one.
- R4: With `clr`=1 and `inc`=0 at an edge, `count` becomes 0.
- R5: An increment from the all-ones count gives 0 (modulo 2^`CNT_W`).
- R6: With `POLICY`=POL_HOLD (encoding 0), `inc`=`clr`=1 keeps the count.
- R7: With `POLICY`=POL_INC (encoding 1), `inc`=`clr`=1 increments the count.
- R8: With `POLICY`=POL_CLR (encoding 2, the default), `inc`=`clr`=1 clears the count.
- R9: With `POLICY`=POL_NEVER (encoding 3), `inc`=`clr`=1 is flagged by an assertion, and the count otherwise behaves exactly as under POL_CLR.
- R10: `z` equals bit `count` of `Z_MASK` in every cycle. Bit k of the mask enables the flag at count value k. For a 3-bit counter with mask 8'b0100_1001, `z` is high exactly at counts 0, 3 and 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inc | input | 1 | Increment request |
| clr | input | 1 | Clear request |
| count | output | CNT_W | Registered current count |
| z | output | 1 | Registered Moore flag decoded from the count |

## Verification
The count register is the whole state and drives the `count` output directly. Any wrong next-state decision, whether a missed increment, a bad wrap or the wrong conflict resolution, therefore appears on `count` in the cycle right after the edge that caused it. The flag is registered from the same next value, so a wrong mask lookup shows on `z` in that same cycle. It stays visible for as long as the count rests on the affected value. Every policy variant runs side by side on the same request stream, so one wrong resolution separates that instance from the bench model within a single cycle.

// File: rtl/cnt_incclr_pkg.sv
package cnt_incclr_pkg;

  // Conflict policy for inc and clr asserted together
  typedef enum logic [1:0] {
    POL_HOLD  = 2'd0,
    POL_INC   = 2'd1,
    POL_CLR   = 2'd2,
    POL_NEVER = 2'd3
  } policy_e;

  // Resolved action for one cycle
  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0,
    ACT_STEP = 2'd1,
    ACT_ZERO = 2'd2
  } action_e;

endpackage

// File: rtl/cnt_incclr_arb.sv
module cnt_incclr_arb
  import cnt_incclr_pkg::*;
#(
  parameter policy_e POLICY = POL_CLR
) (
  input  logic    inc,
  input  logic    clr,
  output action_e act
);

  action_e both_act;

  generate
    if (POLICY == POL_HOLD) begin : g_hold
      assign both_act = ACT_KEEP;
    end else if (POLICY == POL_INC) begin : g_incw
      assign both_act = ACT_STEP;
    end else begin : g_clrw
      // POL_CLR and POL_NEVER share the clear-wins fallback
      assign both_act = ACT_ZERO;
    end
  endgenerate

  always_comb begin
    unique case ({inc, clr})
      2'b00:   act = ACT_KEEP;
      2'b10:   act = ACT_STEP;
      2'b01:   act = ACT_ZERO;
      default: act = both_act;
    endcase
  end

endmodule

// File: rtl/cnt_incclr_nxt.sv
module cnt_incclr_nxt
  import cnt_incclr_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] cur,
  input  action_e          act,
  output logic [CNT_W-1:0] nxt
);

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  always_comb begin
    unique case (act)
      ACT_STEP: nxt = cur + ONE;
      ACT_ZERO: nxt = ZERO;
      default:  nxt = cur;
    endcase
  end

endmodule

// File: rtl/cnt_incclr_dec.sv
module cnt_incclr_dec #(
  parameter int CNT_W = 2,
  localparam int NVAL = 2 ** CNT_W,
  parameter logic [NVAL-1:0] Z_MASK = NVAL'(9)
) (
  input  logic [CNT_W-1:0] val,
  output logic             hit
);

  assign hit = Z_MASK[val];

endmodule

// File: rtl/cnt_incclr.sv
module cnt_incclr
  import cnt_incclr_pkg::*;
#(
  parameter int CNT_W = 2,
  parameter policy_e POLICY = POL_CLR,
  localparam int NVAL = 2 ** CNT_W,
  parameter logic [NVAL-1:0] Z_MASK = NVAL'(9)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             z
);

  action_e          act;
  logic [CNT_W-1:0] cnt_nxt;
  logic             z_nxt;

  cnt_incclr_arb #(.POLICY(POLICY)) u_arb (
    .inc (inc),
    .clr (clr),
    .act (act)
  );

  cnt_incclr_nxt #(.CNT_W(CNT_W)) u_nxt (
    .cur (count),
    .act (act),
    .nxt (cnt_nxt)
  );

  cnt_incclr_dec #(.CNT_W(CNT_W), .Z_MASK(Z_MASK)) u_dec (
    .val (cnt_nxt),
    .hit (z_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      z     <= Z_MASK[0];
    end else begin
      count <= cnt_nxt;
      z     <= z_nxt;
    end
  end

endmodule

// File: rtl/cnt_incclr_chk.sv
module cnt_incclr_chk
  import cnt_incclr_pkg::*;
#(
  parameter int CNT_W = 2,
  parameter policy_e POLICY = POL_CLR,
  localparam int NVAL = 2 ** CNT_W,
  parameter logic [NVAL-1:0] Z_MASK = NVAL'(9)
) (
  input logic             clk,
  input logic             rst,
  input logic             inc,
  input logic             clr,
  input logic [CNT_W-1:0] count,
  input logic             z
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (count == '0)); // R1

  AST_IDLE_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!inc && !clr) |=> (count == $past(count))); // R2

  AST_INC_STEP: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr) |=> (count == CNT_W'($past(count) + ONE))); // R3

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (clr && !inc) |=> (count == '0)); // R4

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && (count == '1)) |=> (count == '0)); // R5

  AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (z == Z_MASK[count])); // R10

  generate
    if (POLICY == POL_HOLD) begin : g_hold
      AST_BOTH_KEEP: assert property (@(posedge clk) disable iff (rst)
        (inc && clr) |=> (count == $past(count))); // R6
    end else if (POLICY == POL_INC) begin : g_incw
      AST_BOTH_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc && clr) |=> (count == CNT_W'($past(count) + ONE))); // R7
    end else if (POLICY == POL_CLR) begin : g_clrw
      AST_BOTH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (inc && clr) |=> (count == '0)); // R8
    end else begin : g_never
      AST_NO_CONFLICT: assert property (@(posedge clk) disable iff (rst)
        !(inc && clr)); // R9
    end
  endgenerate

endmodule

bind cnt_incclr cnt_incclr_chk #(
  .CNT_W  (CNT_W),
  .POLICY (POLICY),
  .Z_MASK (Z_MASK)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .inc   (inc),
  .clr   (clr),
  .count (count),
  .z     (z)
);

// File: tb/cnt_incclr_bench.sv
module cnt_incclr_bench;
  import cnt_incclr_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] MASK2 = 4'b1001;
  localparam logic [7:0] MASK3 = 8'b0100_1001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inc = 1'b0;
  logic clr = 1'b0;
  logic nev_inc;

  logic [1:0] c_def, c_hold, c_incw, c_nev;
  logic [2:0] c_w3;
  logic       z_def, z_hold, z_incw, z_nev, z_w3;

  logic [1:0] e_def, e_hold, e_incw, e_nev;
  logic [2:0] e_w3;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // The never-mode instance must not see a conflict; fold it to clear-only
  assign nev_inc = inc & ~clr;

  cnt_incclr #(.CNT_W(2), .POLICY(POL_CLR), .Z_MASK(MASK2)) u_cnt_incclr (
    .clk(clk), .rst(rst), .inc(inc), .clr(clr), .count(c_def), .z(z_def));
  cnt_incclr #(.CNT_W(2), .POLICY(POL_HOLD), .Z_MASK(MASK2)) u_hold (
    .clk(clk), .rst(rst), .inc(inc), .clr(clr), .count(c_hold), .z(z_hold));
  cnt_incclr #(.CNT_W(2), .POLICY(POL_INC), .Z_MASK(MASK2)) u_incw (
    .clk(clk), .rst(rst), .inc(inc), .clr(clr), .count(c_incw), .z(z_incw));
  cnt_incclr #(.CNT_W(2), .POLICY(POL_NEVER), .Z_MASK(MASK2)) u_never (
    .clk(clk), .rst(rst), .inc(nev_inc), .clr(clr), .count(c_nev), .z(z_nev));
  cnt_incclr #(.CNT_W(3), .POLICY(POL_CLR), .Z_MASK(MASK3)) u_w3 (
    .clk(clk), .rst(rst), .inc(inc), .clr(clr), .count(c_w3), .z(z_w3));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive inputs on the falling edge, update the model, sample after the rise
  task automatic step(logic r, logic i, logic c);
    @(negedge clk);
    rst = r; inc = i; clr = c;
    if (r) begin
      e_def = 0; e_hold = 0; e_incw = 0; e_nev = 0; e_w3 = 0;
    end else if (i && !c) begin
      e_def++; e_hold++; e_incw++; e_nev++; e_w3++;
    end else if (c && !i) begin
      e_def = 0; e_hold = 0; e_incw = 0; e_nev = 0; e_w3 = 0;
    end else if (i && c) begin
      e_def = 0; e_incw++; e_nev = 0; e_w3 = 0;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic check_counts(string req);
    chk({req, " def"},  c_def,  e_def);
    chk({req, " hold"}, c_hold, e_hold);
    chk({req, " incw"}, c_incw, e_incw);
    chk({req, " nev"},  c_nev,  e_nev);
    chk({req, " w3"},   c_w3,   e_w3);
  endtask

  task automatic check_flags(string req);
    chk({req, " z def"}, z_def, MASK2[e_def]);
    chk({req, " z w3"},  z_w3,  MASK3[e_w3]);
  endtask

  task automatic t_reset;
    step(1'b1, 1'b1, 1'b1);
    check_counts("R1");
    check_flags("R1");
  endtask

  task automatic t_increment;
    for (int k = 0; k < 5; k++) begin
      step(1'b0, 1'b1, 1'b0);
      check_counts(k == 3 ? "R5" : "R3");
    end
  endtask

  task automatic t_idle;
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 1'b0, 1'b0);
      check_counts("R2");
    end
  endtask

  task automatic t_clear;
    step(1'b0, 1'b0, 1'b1);
    check_counts("R4");
    step(1'b0, 1'b0, 1'b1);
    check_counts("R4");
  endtask

  task automatic t_flag_sweep;
    for (int k = 0; k < 9; k++) begin
      step(1'b0, 1'b1, 1'b0);
      check_flags("R10");
    end
  endtask

  task automatic t_conflict;
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 1'b1, 1'b1);
      chk("R6 hold",  c_hold, e_hold);
      chk("R7 incw",  c_incw, e_incw);
      chk("R8 def",   c_def,  e_def);
      chk("R9 nev",   c_nev,  e_nev);
      check_flags("R10");
    end
  endtask

  task automatic t_reset_override;
    step(1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    check_counts("R1");
    check_flags("R1");
  endtask

  initial begin
    e_def = 0; e_hold = 0; e_incw = 0; e_nev = 0; e_w3 = 0;
    t_reset();
    step(1'b0, 1'b0, 1'b0);
    t_increment();
    t_idle();
    t_clear();
    t_flag_sweep();
    t_conflict();
    t_reset_override();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule